// File: doc/BRIEF.md
# Per-Core Interrupt Presenter

This block sits between a set of interrupt source controllers and one processor core. It holds a single pending interrupt, tracks the core's current priority, and drives one interrupt line. Source controllers offer a source number with a priority through a valid/ready port. The presenter latches the offer, or refuses it, depending on the current priority and on what is already pending. A refused or displaced external source is handed back to its controller as a reject pulse, and the controller may offer it again later.

Software on the core reaches the block through four register operations. An accept read returns the 32-bit request word and takes the pending interrupt. A priority write moves the core's current priority. An IPI-priority write can place a software interrupt in the pending slot. An end-of-interrupt write restores the priority and forwards the finished source number to the controllers. Lowering the priority value can push out a pending interrupt. Raising it asks the controllers to resend anything they hold back. Lower priority values are more favoured, and 0xFF is the least favoured value, which also means "none".

Top module: `irq_presenter`

## Requirements
- R1: The request word is {current priority in bits 31:24, pending source in bits 23:0}. A source field of 0 means nothing is pending, and `irq_out` is high exactly while a source is pending.
- R2: After reset the request word reads 0x00000000, the pending priority and the IPI priority are both 0xFF, `irq_out` is low and no notification pulse is issued.
- R3: A presented request is refused when its priority is not strictly below the current priority, or when a source is pending with a priority at or below the request's. A refusal emits a reject pulse carrying the request's source and changes no state.
- R4: A request that is not refused replaces the pending one. A displaced external source is rejected, the new source and priority are latched, and `irq_out` rises.
- R5: An accept returns the request word as it stood before the operation on `acc_data`, with `acc_valid` high for one cycle, and lowers `irq_out`. It then loads the current priority with the pending priority, clears the source field and sets the pending priority to 0xFF.
- R6: A priority write whose value (bits 7:0) is below the old priority, while a source is pending with a priority at or above the new value, clears the pending slot, lowers `irq_out` and rejects an external pending source.
- R7: A priority write whose value is above the old priority emits one resend pulse.
- R8: An IPI-priority write (bits 7:0) below the current priority presents source number 2 at that priority and raises `irq_out`. An external source it displaces is rejected.
- R9: The IPI is not presented when the IPI priority is not below the current priority, or when a pending priority is at or below it. A pending IPI that is displaced is never rejected.
- R10: An end-of-interrupt write sets the current priority from bits 31:24 of the written word and emits an EOI pulse carrying bits 23:0.
- R11: `req_ready` is low in any cycle with a register operation, and a presentation offered then is not taken. If several operations are raised together, accept wins over priority write, which wins over IPI write, which wins over end-of-interrupt.
- R12: Each reject, resend or EOI notification is a one-cycle pulse in the cycle after the operation that causes it, and at most one is issued per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Presentation offer from a source controller |
| req_src | input | SRC_W | Offered source number |
| req_prio | input | PRIO_W | Offered priority |
| req_ready | output | 1 | Offer is taken this cycle |
| op_accept | input | 1 | Accept read strobe |
| op_cppr_wr | input | 1 | Current-priority write strobe |
| op_mfrr_wr | input | 1 | IPI-priority write strobe |
| op_eoi_wr | input | 1 | End-of-interrupt write strobe |
| wr_data | input | PRIO_W+SRC_W | Write data for the register operations |
| acc_valid | output | 1 | Accept data valid |
| acc_data | output | PRIO_W+SRC_W | Request word returned by an accept |
| irq_out | output | 1 | Interrupt line to the core |
| rej_valid | output | 1 | Reject notification pulse |
| rej_src | output | SRC_W | Rejected source number |
| rsnd_valid | output | 1 | Resend notification pulse |
| eoi_valid | output | 1 | EOI notification pulse |
| eoi_src | output | SRC_W | Source number being retired |

## Verification
The functions that can fall in the same cycle are a register operation and a presentation offer from a source controller. The bench raises an end-of-interrupt write together with an offer. It checks that `req_ready` is low in that cycle, that only the EOI pulse follows, and that the offer, held until ready, is then latched against the restored priority. A scoreboard queue holds the expected reject, resend and EOI pulses in order, so a pulse that is missing, extra or late shows up as a mismatch.

// File: rtl/irqp_pkg.sv
package irqp_pkg;
  // register operation selected in a cycle, after precedence
  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_ACCEPT = 3'd1,
    OP_CPPR   = 3'd2,
    OP_MFRR   = 3'd3,
    OP_EOI    = 3'd4
  } reg_op_e;
endpackage

// File: rtl/irqp_decide.sv
module irqp_decide
  import irqp_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  reg_op_e                   op,
  input  logic [PRIO_W+SRC_W-1:0]   wdata,
  input  logic                      req_valid,
  input  logic [SRC_W-1:0]          req_src,
  input  logic [PRIO_W-1:0]         req_prio,
  input  logic [PRIO_W-1:0]         cppr,
  input  logic [SRC_W-1:0]          src,
  input  logic [PRIO_W-1:0]         pend,
  input  logic [PRIO_W-1:0]         mfrr,
  input  logic                      own_ext,
  output logic [PRIO_W-1:0]         n_cppr,
  output logic [SRC_W-1:0]          n_src,
  output logic [PRIO_W-1:0]         n_pend,
  output logic [PRIO_W-1:0]         n_mfrr,
  output logic                      n_own_ext,
  output logic                      n_irq,
  output logic                      rej_go,
  output logic [SRC_W-1:0]          rej_id,
  output logic                      rsnd_go,
  output logic                      eoi_go,
  output logic [SRC_W-1:0]          eoi_id
);
  localparam logic [PRIO_W-1:0] LEAST    = '1;
  localparam logic [SRC_W-1:0]  IPI_CODE = SRC_W'(IPI_SRC);

  logic              has;
  logic [PRIO_W-1:0] wprio;

  assign has   = (src != '0);
  assign wprio = wdata[PRIO_W-1:0];

  always_comb begin
    n_cppr    = cppr;
    n_src     = src;
    n_pend    = pend;
    n_mfrr    = mfrr;
    n_own_ext = own_ext;
    n_irq     = has;
    rej_go    = 1'b0;
    rej_id    = '0;
    rsnd_go   = 1'b0;
    eoi_go    = 1'b0;
    eoi_id    = '0;
    unique case (op)
      OP_ACCEPT: begin
        n_cppr    = pend;
        n_src     = '0;
        n_pend    = LEAST;
        n_own_ext = 1'b0;
        n_irq     = 1'b0;
      end
      OP_CPPR: begin
        n_cppr = wprio;
        if (wprio < cppr) begin
          if (has && (wprio <= pend)) begin
            n_src     = '0;
            n_pend    = LEAST;
            n_own_ext = 1'b0;
            n_irq     = 1'b0;
            rej_go    = own_ext;
            rej_id    = own_ext ? src : '0;
          end
        end else if (wprio > cppr) begin
          rsnd_go = 1'b1;
        end
      end
      OP_MFRR: begin
        n_mfrr = wprio;
        if ((wprio < cppr) && !(has && (pend <= wprio))) begin
          rej_go    = has && own_ext;
          rej_id    = (has && own_ext) ? src : '0;
          n_src     = IPI_CODE;
          n_pend    = wprio;
          n_own_ext = 1'b0;
          n_irq     = 1'b1;
        end
      end
      OP_EOI: begin
        n_cppr = wdata[SRC_W +: PRIO_W];
        eoi_go = 1'b1;
        eoi_id = wdata[SRC_W-1:0];
      end
      default: begin
        if (req_valid) begin
          if ((req_prio >= cppr) || (has && (pend <= req_prio))) begin
            rej_go = 1'b1;
            rej_id = req_src;
          end else begin
            rej_go    = has && own_ext;
            rej_id    = (has && own_ext) ? src : '0;
            n_src     = req_src;
            n_pend    = req_prio;
            n_own_ext = 1'b1;
            n_irq     = 1'b1;
          end
        end
      end
    endcase
  end
endmodule

// File: rtl/irqp_pulse.sv
module irqp_pulse #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         go,
  input  logic [W-1:0] id,
  output logic         vld,
  output logic [W-1:0] id_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      vld  <= 1'b0;
      id_q <= '0;
    end else begin
      vld  <= go;
      id_q <= go ? id : '0;
    end
  end
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import irqp_pkg::*;
#(
  parameter int PRIO_W  = 8,
  parameter int SRC_W   = 24,
  parameter int IPI_SRC = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    req_valid,
  input  logic [SRC_W-1:0]        req_src,
  input  logic [PRIO_W-1:0]       req_prio,
  output logic                    req_ready,
  input  logic                    op_accept,
  input  logic                    op_cppr_wr,
  input  logic                    op_mfrr_wr,
  input  logic                    op_eoi_wr,
  input  logic [PRIO_W+SRC_W-1:0] wr_data,
  output logic                    acc_valid,
  output logic [PRIO_W+SRC_W-1:0] acc_data,
  output logic                    irq_out,
  output logic                    rej_valid,
  output logic [SRC_W-1:0]        rej_src,
  output logic                    rsnd_valid,
  output logic                    eoi_valid,
  output logic [SRC_W-1:0]        eoi_src
);
  localparam int REG_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] LEAST = '1;

  reg_op_e           op;
  logic [PRIO_W-1:0] cppr_q, pend_q, mfrr_q;
  logic [SRC_W-1:0]  src_q;
  logic              own_q;
  logic [PRIO_W-1:0] n_cppr, n_pend, n_mfrr;
  logic [SRC_W-1:0]  n_src;
  logic              n_own, n_irq;
  logic              rej_go, rsnd_go, eoi_go;
  logic [SRC_W-1:0]  rej_id, eoi_id;

  // fixed precedence among register operations
  always_comb begin
    if (op_accept)       op = OP_ACCEPT;
    else if (op_cppr_wr) op = OP_CPPR;
    else if (op_mfrr_wr) op = OP_MFRR;
    else if (op_eoi_wr)  op = OP_EOI;
    else                 op = OP_NONE;
  end

  assign req_ready = (op == OP_NONE);

  irqp_decide #(.PRIO_W(PRIO_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_decide (
    .op(op), .wdata(wr_data), .req_valid(req_valid), .req_src(req_src),
    .req_prio(req_prio), .cppr(cppr_q), .src(src_q), .pend(pend_q),
    .mfrr(mfrr_q), .own_ext(own_q), .n_cppr(n_cppr), .n_src(n_src),
    .n_pend(n_pend), .n_mfrr(n_mfrr), .n_own_ext(n_own), .n_irq(n_irq),
    .rej_go(rej_go), .rej_id(rej_id), .rsnd_go(rsnd_go),
    .eoi_go(eoi_go), .eoi_id(eoi_id)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cppr_q    <= '0;
      src_q     <= '0;
      pend_q    <= LEAST;
      mfrr_q    <= LEAST;
      own_q     <= 1'b0;
      irq_out   <= 1'b0;
      acc_valid <= 1'b0;
      acc_data  <= '0;
      rsnd_valid <= 1'b0;
    end else begin
      cppr_q    <= n_cppr;
      src_q     <= n_src;
      pend_q    <= n_pend;
      mfrr_q    <= n_mfrr;
      own_q     <= n_own;
      irq_out   <= n_irq;
      acc_valid <= (op == OP_ACCEPT);
      if (op == OP_ACCEPT) acc_data <= REG_W'({cppr_q, src_q});
      rsnd_valid <= rsnd_go;
    end
  end

  irqp_pulse #(.W(SRC_W)) u_rej (
    .clk(clk), .rst(rst), .go(rej_go), .id(rej_id), .vld(rej_valid), .id_q(rej_src)
  );

  irqp_pulse #(.W(SRC_W)) u_eoi (
    .clk(clk), .rst(rst), .go(eoi_go), .id(eoi_id), .vld(eoi_valid), .id_q(eoi_src)
  );
endmodule

// File: rtl/irqp_checker.sv
module irqp_checker #(
  parameter int PRIO_W = 8,
  parameter int SRC_W  = 24
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic [SRC_W-1:0]        req_src,
  input logic [PRIO_W-1:0]       req_prio,
  input logic                    op_accept,
  input logic                    op_cppr_wr,
  input logic                    op_mfrr_wr,
  input logic                    op_eoi_wr,
  input logic [PRIO_W+SRC_W-1:0] wr_data,
  input logic                    acc_valid,
  input logic                    irq_out,
  input logic                    rej_valid,
  input logic [SRC_W-1:0]        rej_src,
  input logic                    rsnd_valid,
  input logic                    eoi_valid,
  input logic [SRC_W-1:0]        eoi_src,
  input logic [PRIO_W-1:0]       cppr_q
);
  assert_refuse_rejects_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_prio >= cppr_q)) |=>
      (rej_valid && (rej_src == $past(req_src))));

  assert_accept_drops_line_R5: assert property (@(posedge clk) disable iff (rst)
    op_accept |=> (!irq_out && acc_valid));

  assert_resend_on_raise_R7: assert property (@(posedge clk) disable iff (rst)
    (op_cppr_wr && !op_accept && (wr_data[PRIO_W-1:0] > cppr_q)) |=> rsnd_valid);

  assert_eoi_forward_R10: assert property (@(posedge clk) disable iff (rst)
    (op_eoi_wr && !op_accept && !op_cppr_wr && !op_mfrr_wr) |=>
      (eoi_valid && (eoi_src == $past(wr_data[SRC_W-1:0]))
       && (cppr_q == $past(wr_data[SRC_W +: PRIO_W]))));

  assert_single_note_R12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rej_valid, rsnd_valid, eoi_valid}));
endmodule

bind irq_presenter irqp_checker #(.PRIO_W(PRIO_W), .SRC_W(SRC_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_src(req_src), .req_prio(req_prio), .op_accept(op_accept),
  .op_cppr_wr(op_cppr_wr), .op_mfrr_wr(op_mfrr_wr), .op_eoi_wr(op_eoi_wr),
  .wr_data(wr_data), .acc_valid(acc_valid), .irq_out(irq_out),
  .rej_valid(rej_valid), .rej_src(rej_src), .rsnd_valid(rsnd_valid),
  .eoi_valid(eoi_valid), .eoi_src(eoi_src), .cppr_q(cppr_q)
);

// File: tb/test_irq_presenter.sv
`timescale 1ns/1ps
module test_irq_presenter;
  localparam int PW = 8;
  localparam int SW = 24;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [SW-1:0] req_src = '0;
  logic [PW-1:0] req_prio = '0;
  logic          req_ready;
  logic          op_accept = 1'b0, op_cppr_wr = 1'b0, op_mfrr_wr = 1'b0, op_eoi_wr = 1'b0;
  logic [31:0]   wr_data = '0;
  logic          acc_valid;
  logic [31:0]   acc_data;
  logic          irq_out, rej_valid, rsnd_valid, eoi_valid;
  logic [SW-1:0] rej_src, eoi_src;

  int total = 0;
  int bad = 0;

  // kinds: 0 reject, 1 resend, 2 eoi
  typedef struct { int kind; logic [SW-1:0] id; string rq; } note_t;
  note_t sb[$];

  always #2.5 clk = ~clk;

  irq_presenter i_irq_presenter (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_src(req_src),
    .req_prio(req_prio), .req_ready(req_ready), .op_accept(op_accept),
    .op_cppr_wr(op_cppr_wr), .op_mfrr_wr(op_mfrr_wr), .op_eoi_wr(op_eoi_wr),
    .wr_data(wr_data), .acc_valid(acc_valid), .acc_data(acc_data),
    .irq_out(irq_out), .rej_valid(rej_valid), .rej_src(rej_src),
    .rsnd_valid(rsnd_valid), .eoi_valid(eoi_valid), .eoi_src(eoi_src)
  );

  task automatic check(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  task automatic expect_note(input int kind, input logic [SW-1:0] id, input string rq);
    note_t n;
    n.kind = kind; n.id = id; n.rq = rq;
    sb.push_back(n);
  endtask

  // monitor: every notification pulse is popped and compared
  always @(negedge clk) begin
    if (!rst && (rej_valid || rsnd_valid || eoi_valid)) begin
      int k;
      logic [SW-1:0] id;
      k  = rej_valid ? 0 : (rsnd_valid ? 1 : 2);
      id = rej_valid ? rej_src : (eoi_valid ? eoi_src : '0);
      if (sb.size() == 0) begin
        check(1'b0, "R12 unexpected pulse", {8'(k), id}, 32'hFFFFFFFF);
      end else begin
        note_t n;
        n = sb.pop_front();
        check((n.kind == k) && (n.id == id), n.rq, {8'(k), id}, {8'(n.kind), n.id});
      end
    end
  end

  task automatic present(input logic [SW-1:0] s, input logic [PW-1:0] p);
    req_valid = 1'b1; req_src = s; req_prio = p;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic accept(input logic [31:0] exp, input string rq);
    op_accept = 1'b1;
    @(negedge clk);
    op_accept = 1'b0;
    check(acc_valid && acc_data == exp, rq, acc_data, exp);
    check(!irq_out, "R5 line low after accept", 32'(irq_out), 0);
  endtask

  task automatic regwr(input int which, input logic [31:0] d);
    wr_data = d;
    if (which == 0) op_cppr_wr = 1'b1;
    else if (which == 1) op_mfrr_wr = 1'b1;
    else op_eoi_wr = 1'b1;
    @(negedge clk);
    op_cppr_wr = 1'b0; op_mfrr_wr = 1'b0; op_eoi_wr = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd1, 32'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!irq_out, "R2 line low at reset", 32'(irq_out), 0);
    check(req_ready, "R2 ready at reset", 32'(req_ready), 1);
    accept(32'h00000000, "R2 reset word");               // cppr now FF

    present(24'h10, 8'd5);
    check(irq_out, "R4 line raised", 32'(irq_out), 1);
    expect_note(0, 24'h20, "R3 refuse equal pending");
    present(24'h20, 8'd5);
    expect_note(0, 24'h10, "R4 displaced rejected");
    present(24'h30, 8'd3);
    check(irq_out, "R4 line still high", 32'(irq_out), 1);
    accept(32'hFF000030, "R1 R5 accept word");           // cppr 3

    expect_note(0, 24'h40, "R3 refuse at cppr");
    present(24'h40, 8'd3);
    check(!irq_out, "R3 no state change", 32'(irq_out), 0);
    present(24'h41, 8'd1);
    expect_note(0, 24'h41, "R6 cull on lower");
    regwr(0, 32'h00);
    check(!irq_out, "R6 line dropped", 32'(irq_out), 0);
    expect_note(1, '0, "R7 resend on raise");
    regwr(0, 32'h06);
    expect_note(2, 24'h30, "R10 eoi pulse");
    regwr(2, 32'h0A000030);                              // cppr 0A

    regwr(1, 32'h04);
    check(irq_out, "R8 ipi raised", 32'(irq_out), 1);
    accept(32'h0A000002, "R8 ipi word");                 // cppr 4
    regwr(1, 32'h04);
    check(!irq_out, "R9 ipi not below cppr", 32'(irq_out), 0);
    accept(32'h04000000, "R9 nothing pending");          // cppr FF

    regwr(1, 32'h02);
    present(24'h50, 8'd1);                               // displaces ipi, no reject
    regwr(1, 32'h03);                                    // pending 1 blocks ipi
    accept(32'hFF000050, "R9 ipi displaced silently");   // cppr 1

    // register op and presentation in the same cycle
    expect_note(2, 24'h50, "R11 eoi wins cycle");
    op_eoi_wr = 1'b1; wr_data = 32'hFF000050;
    req_valid = 1'b1; req_src = 24'h60; req_prio = 8'd7;
    #1 check(!req_ready, "R11 ready low with op", 32'(req_ready), 0);
    @(negedge clk);
    op_eoi_wr = 1'b0;
    #1 check(req_ready, "R11 ready back", 32'(req_ready), 1);
    @(negedge clk);
    req_valid = 1'b0;
    check(irq_out, "R11 held offer taken", 32'(irq_out), 1);
    accept(32'hFF000060, "R11 offer latched after eoi"); // cppr 7

    present(24'h70, 8'd6);
    expect_note(0, 24'h70, "R8 ipi rejects external");
    regwr(1, 32'h05);
    accept(32'h07000002, "R8 ipi over external");

    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R12 missing pulses", 32'(sb.size()), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule